// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block reads a chain of memory descriptors and turns each one into a segment: a buffer address and a byte count. A single start pulse loads the list base address. The walker then reads two 32-bit words for each descriptor, one at a time, through a plain request/response memory port. It presents the decoded segment on a valid/ready output and moves on to the next descriptor only after the consumer has taken that segment.

Each descriptor occupies eight bytes. The count word is at byte offset 0 and the address word is at byte offset 4. Bit 31 of the count word marks the final descriptor. The walk ends at that descriptor, or when a parameterised number of descriptors has been read without a final marker. In the second case the walk also raises an error flag. The end of every walk is signalled by a one-cycle completion pulse.

Top module: `sg_list_walker`

## Requirements
- R1: After reset, rd_req_valid, seg_valid, done and error are all low.
- R2: For descriptor i, the walker requests the count word at base + 8*i and then the address word at base + 8*i + 4. It issues a request only after the response to the previous request has arrived, so at most one read is in flight. While a request waits for rd_req_ready, its address is held stable.
- R3: seg_len equals the count word with bits 31..28 cleared. Bit 31 is the final-descriptor flag, and bits 30..28 are discarded.
- R4: seg_addr equals the address word with bit 31 cleared.
- R5: A segment is presented only after both of its words have returned. seg_addr and seg_len are held stable until seg_ready is sampled high. No read request is issued while a segment is waiting to be accepted.
- R6: When the accepted segment carries the final flag, done is high for exactly one cycle, in the cycle after the acceptance. No further read request follows.
- R7: The limit is MAX_ENTRIES descriptors, 32 by default. If that many segments are accepted and none carries the final flag, the walk stops and done pulses one cycle after the last acceptance. error rises in the same cycle and stays high until the next start.
- R8: A start pulse that arrives while a walk is in progress has no effect. The running walk keeps its own base address.
- R9: A start pulse accepted while idle clears error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; accepted only while idle |
| start_base | input | 32 | Byte address of descriptor 0 |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read data is returning |
| rd_rsp_data | input | 32 | Returned word, little-endian |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | 32 | Buffer address (bit 31 cleared) |
| seg_len | output | 32 | Buffer length (bits 31..28 cleared) |
| done | output | 1 | One-cycle pulse at the end of a walk |
| error | output | 1 | Set when the limit is reached without a final flag |

## Verification
A corrupted descriptor index or base register appears at once as a wrong rd_req_addr, on the first request after the fault. The bench therefore compares the full request address sequence, word by word, against base + 8*i (+4). A wrong captured word or mask shows up on the next presented segment. A miscounted limit or a lost final flag shows up as an extra or missing request, and as a done or error that is early or late by a full descriptor. The bench checks the exact cycle of done against the final acceptance, and the total request count after the walk ends.

// File: rtl/sg_list_walker.sv
module sg_list_walker #(
  parameter int MAX_ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_base,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        seg_valid,
  input  logic        seg_ready,
  output logic [31:0] seg_addr,
  output logic [31:0] seg_len,
  output logic        done,
  output logic        error
);

  localparam int IDX_W = (MAX_ENTRIES > 2) ? $clog2(MAX_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_ENTRIES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_LEN, S_WAIT_LEN, S_REQ_ADR, S_WAIT_ADR, S_OUT, S_FIN
  } state_t;

  state_t           st;
  logic [31:0]      base_q;
  logic [IDX_W-1:0] idx;
  logic [27:0]      len_q;
  logic [30:0]      adr_q;
  logic             last_q;
  logic             err_q;
  logic [31:0]      entry_addr;

  assign entry_addr   = base_q + (32'(idx) << 3);
  assign rd_req_valid = (st == S_REQ_LEN) || (st == S_REQ_ADR);
  assign rd_req_addr  = entry_addr + ((st == S_REQ_ADR) ? 32'd4 : 32'd0);
  assign seg_valid    = (st == S_OUT);
  assign seg_addr     = {1'b0, adr_q};
  assign seg_len      = {4'b0, len_q};
  assign done         = (st == S_FIN);
  assign error        = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base_q <= '0;
      idx    <= '0;
      len_q  <= '0;
      adr_q  <= '0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q <= start_base;
          idx    <= '0;
          err_q  <= 1'b0;
          st     <= S_REQ_LEN;
        end
        S_REQ_LEN: if (rd_req_ready) st <= S_WAIT_LEN;
        S_WAIT_LEN: if (rd_rsp_valid) begin
          len_q  <= rd_rsp_data[27:0];
          last_q <= rd_rsp_data[31];
          st     <= S_REQ_ADR;
        end
        S_REQ_ADR: if (rd_req_ready) st <= S_WAIT_ADR;
        S_WAIT_ADR: if (rd_rsp_valid) begin
          adr_q <= rd_rsp_data[30:0];
          st    <= S_OUT;
        end
        S_OUT: if (seg_ready) begin
          if (last_q) begin
            st <= S_FIN;
          end else if (idx == IDX_LAST) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_REQ_LEN;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R2

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_addr) && $stable(seg_len)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_AFTER_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(seg_valid && seg_ready)); // R6

  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done); // R7

  AST_NO_REQ_DURING_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> !rd_req_valid); // R5

endmodule

// File: tb/test_sg_list_walker.sv
module test_sg_list_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_base = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [31:0] seg_addr, seg_len;
  logic        done, error;

  sg_list_walker #(.MAX_ENTRIES(32)) i_sg_list_walker (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:255];
  logic [31:0] req_log [0:127];
  logic [31:0] sa_log [0:63];
  logic [31:0] sl_log [0:63];
  int nreq, nseg, cyc, acc_cyc, done_cyc, hold_bad;
  bit done_seen, stall, pend_prev;
  logic [31:0] paddr, prev_a, prev_l;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  initial begin
    cyc = 0; nreq = 0; nseg = 0; hold_bad = 0; done_seen = 0; stall = 0; pend_prev = 0;
    acc_cyc = 0; done_cyc = 0; paddr = '0; prev_a = '0; prev_l = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rd_rsp_valid) rd_rsp_valid = 1'b0;
      if (rd_req_ready) begin
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[paddr[9:2]];
      end else if (rd_req_valid) begin
        rd_req_ready = 1'b1;
        paddr = rd_req_addr;
        if (nreq < 128) req_log[nreq] = rd_req_addr;
        nreq++;
      end
      if (pend_prev && !(seg_valid && seg_addr == prev_a && seg_len == prev_l)) hold_bad++;
      seg_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (seg_valid && seg_ready) begin
        if (nseg < 64) begin sa_log[nseg] = seg_addr; sl_log[nseg] = seg_len; end
        nseg++;
        acc_cyc = cyc;
      end
      pend_prev = seg_valid && !seg_ready;
      prev_a = seg_addr; prev_l = seg_len;
      if (done) begin done_seen = 1; done_cyc = cyc; end
    end
  end

  task automatic put(input logic [31:0] base, input int i, input logic [31:0] lw, input logic [31:0] aw);
    mem[(base + 32'(i) * 8) >> 2]       = lw;
    mem[((base + 32'(i) * 8) >> 2) + 1] = aw;
  endtask

  task automatic walk(input logic [31:0] base, input int intrude_at, input logic [31:0] other);
    nreq = 0; nseg = 0; done_seen = 0; hold_bad = 0;
    @(negedge clk); start = 1'b1; start_base = base;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3000 && !done_seen; k++) begin
      @(negedge clk);
      if (k == intrude_at) begin start = 1'b1; start_base = other; end
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic chk_reqs(input logic [31:0] base, input int n_exp, input string tag);
    chk(nreq == n_exp, {tag, " request count"}, 32'(nreq), 32'(n_exp));
    for (int i = 0; i < n_exp && i < 128; i++)
      chk(req_log[i] == base + 32'(i / 2) * 8 + 32'(i % 2) * 4, {tag, " request address"},
          req_log[i], base + 32'(i / 2) * 8 + 32'(i % 2) * 4);
  endtask

  task automatic t_reset;
    chk(!rd_req_valid && !seg_valid && !done && !error, "R1 reset outputs",
        {28'd0, rd_req_valid, seg_valid, done, error}, 32'd0);
  endtask

  task automatic t_three;
    put(32'h100, 0, 32'h7123_0040, 32'hFFFF_0000);
    put(32'h100, 1, 32'h0000_0200, 32'h8000_1234);
    put(32'h100, 2, 32'h8000_0010, 32'h0000_4000);
    walk(32'h100, -1, 0);
    chk_reqs(32'h100, 6, "R2 three entries");
    chk(nseg == 3, "R6 segment count", 32'(nseg), 3);
    chk(sl_log[0] == 32'h0123_0040, "R3 length masks bits 30..28", sl_log[0], 32'h0123_0040);
    chk(sl_log[2] == 32'h10, "R3 length drops last flag", sl_log[2], 32'h10);
    chk(sa_log[0] == 32'h7FFF_0000, "R4 address mask", sa_log[0], 32'h7FFF_0000);
    chk(sa_log[1] == 32'h0000_1234, "R4 address bit 31", sa_log[1], 32'h1234);
    chk(done_seen && done_cyc == acc_cyc + 1, "R6 done one cycle after acceptance",
        32'(done_cyc), 32'(acc_cyc + 1));
    chk(!error, "R6 no error on terminated list", {31'd0, error}, 0);
  endtask

  task automatic t_stall;
    put(32'h040, 0, 32'h0000_0ABC, 32'h0000_2000);
    put(32'h040, 1, 32'h8FFF_FFFF, 32'h7000_0008);
    stall = 1;
    walk(32'h040, -1, 0);
    stall = 0;
    chk(hold_bad == 0, "R5 segment held under backpressure", 32'(hold_bad), 0);
    chk_reqs(32'h040, 4, "R5 no extra reads under backpressure");
    chk(sl_log[1] == 32'h0FFF_FFFF && sa_log[1] == 32'h7000_0008, "R3 R4 second segment",
        sl_log[1], 32'h0FFF_FFFF);
    chk(done_cyc == acc_cyc + 1, "R6 done timing with stalls", 32'(done_cyc), 32'(acc_cyc + 1));
  endtask

  task automatic t_single_and_busy;
    put(32'h080, 0, 32'h0000_0004, 32'h0000_0100);
    put(32'h080, 1, 32'h8000_0008, 32'h0000_0200);
    put(32'h0C0, 0, 32'h8000_0001, 32'h0000_0300);
    walk(32'h0C0, -1, 0);
    chk_reqs(32'h0C0, 2, "R6 single entry");
    chk(nseg == 1 && sa_log[0] == 32'h300, "R6 single segment", sa_log[0], 32'h300);
    walk(32'h080, 1, 32'h0C0);
    chk_reqs(32'h080, 4, "R8 start ignored while busy");
    chk(nseg == 2 && sa_log[1] == 32'h200, "R8 walk unchanged", sa_log[1], 32'h200);
  endtask

  task automatic t_limit;
    for (int i = 0; i < 32; i++) put(32'h200, i, 32'(i + 1), 32'h1000 + 32'(i));
    put(32'h200, 32, 32'h8000_0000, 32'h0);
    walk(32'h200, -1, 0);
    chk_reqs(32'h200, 64, "R7 limit reached");
    chk(nseg == 32, "R7 all segments emitted", 32'(nseg), 32);
    chk(sl_log[31] == 32'd32 && sa_log[31] == 32'h101F, "R7 last segment", sa_log[31], 32'h101F);
    chk(done_cyc == acc_cyc + 1, "R7 done after limit", 32'(done_cyc), 32'(acc_cyc + 1));
    chk(error, "R7 error held after walk", {31'd0, error}, 1);
    repeat (10) @(negedge clk);
    chk(error, "R7 error still held", {31'd0, error}, 1);
    @(negedge clk); start = 1'b1; start_base = 32'h0C0;
    @(negedge clk); start = 1'b0;
    chk(!error, "R9 start clears error", {31'd0, error}, 0);
    repeat (40) @(negedge clk);
    chk(!error, "R9 error stays clear after good walk", {31'd0, error}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_three();
    t_stall();
    t_single_and_busy();
    t_limit();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'(cyc), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule